// File: doc/BRIEF.md
# Daisy-Chain Serial DAC Host Controller

This controller sits on the host side of a chain of dual-channel 12-bit serial converters. All the converters share one serial clock and one active-low select line, which also acts as the load strobe. The data line of each converter feeds the next one in the chain. One request hands the controller a code for every channel of every device. The controller then shifts one long bit stream through the whole chain, raises the select line once so that every device latches its pair of codes together, and reports ready again only after that load pulse has finished.

The code word is flat. Channel c of device d sits at bits `[(d*2+c)*CODE_W +: CODE_W]`, with c = 0 for channel A and c = 1 for channel B. Device 0 is wired closest to the host and device N_DEV-1 is farthest away. Each phase of the serial waveform lasts a fixed number of system-clock cycles, and each of those counts is a parameter. The clock-low-before-select rule, the select-to-clock setup, the high and low widths, the last-clock-to-load spacing and the load width are therefore met by construction. The controller also shifts in the serial data that comes back from the far end of the chain, so the host can check what the chain held before the write.

The state machine has six states:
- IDLE: select high, ready high.
- SETUP: select low, clock low, first bit driven.
- HIGH: serial clock high.
- LOW: serial clock low, next bit driven.
- TAIL: clock low after the final bit.
- LOAD: select high, latching.

It makes these transitions:
- IDLE to SETUP when start is seen.
- SETUP to HIGH after T_SETUP cycles.
- HIGH to LOW after T_HIGH cycles while bits remain.
- HIGH to TAIL after T_HIGH cycles on the last bit.
- LOW to HIGH after T_LOW cycles.
- TAIL to LOAD after T_TAIL cycles.
- LOAD to IDLE after T_LOAD cycles.

Top module: `dac_chain_host`

## Requirements
- R1: During and right after reset, ready is 1, sel_n is 1, sclk is 0 and rd_data is all zeros.
- R2: A start in a cycle where ready is 1 is accepted, and codes_in is captured in that cycle. In the next cycle ready is 0 and sel_n is 0. Changes on codes_in and start pulses are ignored while ready is 0, so the devices latch the codes that were captured.
- R3: sel_n falls only while sclk is 0, and sclk is never 1 while sel_n is 1. The first sclk rise comes exactly T_SETUP cycles after sel_n falls.
- R4: Every sclk high phase lasts exactly T_HIGH cycles. Every low phase between two rises lasts exactly T_LOW cycles.
- R5: Each update has exactly 24*N_DEV sclk rises between the fall of sel_n and its next rise.
- R6: The stream, most significant bit first, runs from device N_DEV-1 down to device 0. For each device it sends the 12-bit channel A code MSB first, then the 12-bit channel B code MSB first. After the update, every device holds the codes given for it.
- R7: sdata changes only while sclk is 0 and is stable during every high phase.
- R8: After the last high phase, sclk stays 0 for exactly T_TAIL cycles and then sel_n rises. sel_n then stays 1 for T_LOAD cycles before ready returns to 1.
- R9: Each update produces exactly one sel_n rising edge, and that single edge updates every device in the chain.
- R10: At each sclk rise the controller samples sdo_ret into rd_data, with the first sample ending up in the MSB. When ready returns, rd_data equals the 24*N_DEV-bit stream that the chain held before the update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request an update; taken when ready is 1 |
| codes_in | input | N_DEV*2*CODE_W | Channel codes; device d channel c at (d*2+c)*CODE_W |
| ready | output | 1 | Controller idle, request can be taken |
| sclk | output | 1 | Serial clock to the chain |
| sdata | output | 1 | Serial data to the nearest device |
| sel_n | output | 1 | Active-low select; its rising edge loads the chain |
| sdo_ret | input | 1 | Serial data returned from the farthest device |
| rd_data | output | N_DEV*2*CODE_W | Stream shifted back during the last update |

## Verification
The assertions assume that start may arrive at any time and that sdo_ret may change at any sclk rise. They make no assumption about how long the timing counts are, beyond each being at least 1.

The bench chains behavioural shift-register devices that shift only while select is low and drive their output from the register MSB. The bench keeps every timing count long enough that the returned bit settles before the next rise. It drives start and codes_in half a cycle away from the sampling edge. While a transfer is running, it scrambles codes_in and pulses start, so that the ignore rule in R2 is exercised without breaking any input assumption.

// File: rtl/dac_chain_pkg.sv
package dac_chain_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_HIGH,
        ST_LOW,
        ST_TAIL,
        ST_LOAD
    } dcs_state_t;

endpackage

// File: rtl/dac_chain_framer.sv
module dac_chain_framer #(
    parameter int N_DEV      = 2,
    parameter int CH_PER_DEV = 2,
    parameter int CODE_W     = 12
) (
    input  logic [N_DEV*CH_PER_DEV*CODE_W-1:0] codes,
    output logic [N_DEV*CH_PER_DEV*CODE_W-1:0] frame
);
    localparam int TOTAL = N_DEV * CH_PER_DEV * CODE_W;

    // Farthest device first; within a device, channel A before channel B.
    for (genvar d = 0; d < N_DEV; d++) begin : g_dev
        for (genvar c = 0; c < CH_PER_DEV; c++) begin : g_ch
            localparam int SLOT = (N_DEV - 1 - d) * CH_PER_DEV + c;
            assign frame[TOTAL-1-SLOT*CODE_W -: CODE_W] =
                codes[(d*CH_PER_DEV+c)*CODE_W +: CODE_W];
        end
    end
endmodule

// File: rtl/dac_chain_host.sv
module dac_chain_host
    import dac_chain_pkg::*;
#(
    parameter int N_DEV      = 2,
    parameter int CH_PER_DEV = 2,
    parameter int CODE_W     = 12,
    parameter int T_SETUP    = 1,
    parameter int T_HIGH     = 2,
    parameter int T_LOW      = 2,
    parameter int T_TAIL     = 2,
    parameter int T_LOAD     = 3
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               start,
    input  logic [N_DEV*CH_PER_DEV*CODE_W-1:0] codes_in,
    output logic                               ready,
    output logic                               sclk,
    output logic                               sdata,
    output logic                               sel_n,
    input  logic                               sdo_ret,
    output logic [N_DEV*CH_PER_DEV*CODE_W-1:0] rd_data
);
    localparam int TOTAL = N_DEV * CH_PER_DEV * CODE_W;
    localparam int TMAX1 = (T_SETUP > T_HIGH) ? T_SETUP : T_HIGH;
    localparam int TMAX2 = (T_LOW > T_TAIL) ? T_LOW : T_TAIL;
    localparam int TMAX3 = (TMAX1 > TMAX2) ? TMAX1 : TMAX2;
    localparam int TMAX  = (TMAX3 > T_LOAD) ? TMAX3 : T_LOAD;
    localparam int CNT_W = $clog2(TMAX + 1) + 1;
    localparam int BIT_W = $clog2(TOTAL);
    localparam int RCH_W = $clog2(TOTAL + 1) + 1;

    localparam logic [CNT_W-1:0] K_SETUP = CNT_W'(T_SETUP - 1);
    localparam logic [CNT_W-1:0] K_HIGH  = CNT_W'(T_HIGH - 1);
    localparam logic [CNT_W-1:0] K_LOW   = CNT_W'(T_LOW - 1);
    localparam logic [CNT_W-1:0] K_TAIL  = CNT_W'(T_TAIL - 1);
    localparam logic [CNT_W-1:0] K_LOAD  = CNT_W'(T_LOAD - 1);
    localparam logic [BIT_W-1:0] K_BITS  = BIT_W'(TOTAL - 1);

    dcs_state_t             state;
    logic [CNT_W-1:0]       cnt;
    logic [BIT_W-1:0]       bits_left;
    logic [TOTAL-1:0]       shift_q;
    logic [TOTAL-1:0]       rd_q;
    logic [TOTAL-1:0]       frame;

    dac_chain_framer #(
        .N_DEV      (N_DEV),
        .CH_PER_DEV (CH_PER_DEV),
        .CODE_W     (CODE_W)
    ) u_framer (
        .codes (codes_in),
        .frame (frame)
    );

    // State register, phase counter, bit counter and data shifters.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            cnt       <= '0;
            bits_left <= '0;
            shift_q   <= '0;
            rd_q      <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        shift_q   <= frame;
                        cnt       <= K_SETUP;
                        bits_left <= K_BITS;
                        state     <= ST_SETUP;
                    end
                end
                ST_SETUP: begin
                    if (cnt == '0) begin
                        cnt   <= K_HIGH;
                        rd_q  <= {rd_q[TOTAL-2:0], sdo_ret};
                        state <= ST_HIGH;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                ST_HIGH: begin
                    if (cnt == '0) begin
                        if (bits_left == '0) begin
                            cnt   <= K_TAIL;
                            state <= ST_TAIL;
                        end else begin
                            cnt       <= K_LOW;
                            bits_left <= bits_left - 1'b1;
                            shift_q   <= {shift_q[TOTAL-2:0], 1'b0};
                            state     <= ST_LOW;
                        end
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                ST_LOW: begin
                    if (cnt == '0) begin
                        cnt   <= K_HIGH;
                        rd_q  <= {rd_q[TOTAL-2:0], sdo_ret};
                        state <= ST_HIGH;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                ST_TAIL: begin
                    if (cnt == '0) begin
                        cnt   <= K_LOAD;
                        state <= ST_LOAD;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                ST_LOAD: begin
                    if (cnt == '0) begin
                        state <= ST_IDLE;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Output decode from the state register.
    always_comb begin
        ready = 1'b0;
        sclk  = 1'b0;
        sel_n = 1'b0;
        unique case (state)
            ST_IDLE:  begin ready = 1'b1; sel_n = 1'b1; end
            ST_SETUP: ;
            ST_HIGH:  sclk = 1'b1;
            ST_LOW:   ;
            ST_TAIL:  ;
            ST_LOAD:  sel_n = 1'b1;
            default:  sel_n = 1'b1;
        endcase
    end

    assign sdata   = shift_q[TOTAL-1];
    assign rd_data = rd_q;

    // Checker state for the width and count properties.
    logic [CNT_W-1:0] chk_hi;
    logic [RCH_W-1:0] chk_rises;
    logic             chk_sclk_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chk_hi     <= '0;
            chk_rises  <= '0;
            chk_sclk_d <= 1'b0;
        end else begin
            chk_sclk_d <= sclk;
            chk_hi     <= sclk ? chk_hi + 1'b1 : '0;
            if (sel_n)
                chk_rises <= '0;
            else if (sclk && !chk_sclk_d)
                chk_rises <= chk_rises + 1'b1;
        end
    end

    a_r3_sel_fall_clk_low: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sel_n) |-> !sclk);

    a_r3_no_clk_deselected: assert property (@(posedge clk) disable iff (!rst_n)
        sel_n |-> !sclk);

    a_r2_ready_idle_lines: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> (sel_n && !sclk));

    a_r7_data_hold_high: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk && $past(sclk)) |-> $stable(sdata));

    a_r4_high_width: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sclk) |-> (chk_hi == CNT_W'(T_HIGH)));

    a_r5_bit_total: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sel_n) |-> (chk_rises == RCH_W'(TOTAL)));

endmodule

// File: tb/dac_chain_host_tb.sv
module dac_chain_host_tb;
    localparam int N_DEV   = 2;
    localparam int CODE_W  = 12;
    localparam int TOTAL   = N_DEV * 2 * CODE_W;
    localparam int T_SETUP = 1;
    localparam int T_HIGH  = 2;
    localparam int T_LOW   = 2;
    localparam int T_TAIL  = 2;
    localparam int T_LOAD  = 3;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic [TOTAL-1:0] codes_in = '0;
    logic             ready, sclk, sdata, sel_n, sdo_ret;
    logic [TOTAL-1:0] rd_data;

    int errors = 0;
    int checks = 0;

    always #10 clk = ~clk;

    dac_chain_host #(
        .N_DEV(N_DEV), .CH_PER_DEV(2), .CODE_W(CODE_W),
        .T_SETUP(T_SETUP), .T_HIGH(T_HIGH), .T_LOW(T_LOW),
        .T_TAIL(T_TAIL), .T_LOAD(T_LOAD)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .codes_in(codes_in),
        .ready(ready), .sclk(sclk), .sdata(sdata), .sel_n(sel_n),
        .sdo_ret(sdo_ret), .rd_data(rd_data)
    );

    // Behavioural chain of dual-channel serial devices.
    logic [23:0]       sreg  [N_DEV];
    logic [CODE_W-1:0] lat_a [N_DEV];
    logic [CODE_W-1:0] lat_b [N_DEV];
    logic              armed = 1'b0;

    initial begin
        for (int i = 0; i < N_DEV; i++) begin
            sreg[i]  = '0;
            lat_a[i] = '0;
            lat_b[i] = '0;
        end
    end

    always @(posedge sclk) begin
        if (!sel_n) begin
            for (int i = 0; i < N_DEV; i++)
                sreg[i] <= {sreg[i][22:0], (i == 0) ? sdata : sreg[(i == 0) ? 0 : i-1][23]};
        end
    end

    always @(posedge sel_n) begin
        if (armed) begin
            for (int i = 0; i < N_DEV; i++) begin
                lat_a[i] <= sreg[i][23:12];
                lat_b[i] <= sreg[i][11:0];
            end
        end
    end

    assign sdo_ret = sreg[N_DEV-1][23];

    // Port-level timing monitor, sampled on the falling clock edge.
    logic mon_en = 1'b0;
    logic p_sclk = 1'b0, p_sel = 1'b1, p_sdata = 1'b0, p_ready = 1'b1;
    int hi_run = 0, lo_run = 0, rises = 0, rises_at_load = 0, pulses = 0, ld_cnt = 0;
    int v_setup = 0, v_high = 0, v_low = 0, v_tail = 0, v_load = 0, v_selclk = 0, v_data = 0;

    always @(negedge clk) begin
        if (mon_en) begin
            if (sclk && p_sclk && (sdata != p_sdata)) v_data++;
            if (sel_n && sclk) v_selclk++;
            if (p_sel && !sel_n && (p_sclk || sclk)) v_selclk++;
            if (sclk) hi_run++;
            else if (p_sclk) begin
                if (hi_run != T_HIGH) v_high++;
                hi_run = 0;
            end
            if (!sel_n && !sclk) lo_run++;
            if (sclk && !p_sclk) begin
                if (rises == 0) begin
                    if (lo_run != T_SETUP) v_setup++;
                end else if (lo_run != T_LOW) v_low++;
                lo_run = 0;
                rises++;
            end
            if (sel_n && !p_sel) begin
                if (lo_run != T_TAIL) v_tail++;
                rises_at_load = rises;
                rises = 0;
                lo_run = 0;
                pulses++;
                ld_cnt = 1;
            end else if (sel_n && !ready) ld_cnt++;
            if (ready && !p_ready && (ld_cnt != T_LOAD)) v_load++;
            p_sclk  = sclk;
            p_sel   = sel_n;
            p_sdata = sdata;
            p_ready = ready;
        end
    end

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [TOTAL-1:0] make_frame(input logic [TOTAL-1:0] codes);
        logic [TOTAL-1:0] f = '0;
        for (int d = 0; d < N_DEV; d++)
            for (int c = 0; c < 2; c++)
                f[TOTAL-1-((N_DEV-1-d)*2+c)*CODE_W -: CODE_W] = codes[(d*2+c)*CODE_W +: CODE_W];
        return f;
    endfunction

    logic [TOTAL-1:0] prev_frame = '0;

    task automatic step;
        @(negedge clk);
        #1;
    endtask

    task automatic xfer(input logic [TOTAL-1:0] codes, input bit poke);
        int bad_dev;
        while (!ready) step();
        v_setup = 0; v_high = 0; v_low = 0; v_tail = 0;
        v_load = 0; v_selclk = 0; v_data = 0; pulses = 0;
        codes_in = codes;
        start    = 1'b1;
        step();
        start    = 1'b0;
        check(!ready && !sel_n, "R2 busy after accept", {62'd0, ready, sel_n}, 64'd0);
        codes_in = ~codes;
        if (poke) begin
            repeat (20) step();
            start = 1'b1;
            step();
            start = 1'b0;
        end
        while (!ready) step();
        bad_dev = 0;
        for (int d = 0; d < N_DEV; d++) begin
            if (lat_a[d] != codes[(d*2)*CODE_W +: CODE_W]) bad_dev++;
            if (lat_b[d] != codes[(d*2+1)*CODE_W +: CODE_W]) bad_dev++;
        end
        check(bad_dev == 0, "R6 R2 device codes",
              {40'd0, lat_a[N_DEV-1], lat_a[0]},
              {40'd0, codes[(2*N_DEV-2)*CODE_W +: CODE_W], codes[0 +: CODE_W]});
        check(rd_data == prev_frame, "R10 readback", 64'(rd_data), 64'(prev_frame));
        check(rises_at_load == TOTAL, "R5 rise count", 64'(rises_at_load), 64'(TOTAL));
        check(pulses == 1, "R9 load pulses", 64'(pulses), 64'd1);
        check(v_selclk == 0 && v_setup == 0, "R3 select and setup", 64'(v_selclk + v_setup), 64'd0);
        check(v_high == 0 && v_low == 0, "R4 clock widths", 64'(v_high + v_low), 64'd0);
        check(v_data == 0, "R7 data hold", 64'(v_data), 64'd0);
        check(v_tail == 0 && v_load == 0, "R8 tail and load", 64'(v_tail + v_load), 64'd0);
        prev_frame = make_frame(codes);
        codes_in = '0;
    endtask

    initial begin
        #(20 * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [TOTAL-1:0] rc;
        void'($urandom(32'd24681));
        repeat (3) @(negedge clk);
        check(ready && sel_n && !sclk, "R1 during reset", {61'd0, ready, sel_n, sclk}, 64'd6);
        rst_n = 1'b1;
        step();
        check(ready && sel_n && !sclk, "R1 after reset", {61'd0, ready, sel_n, sclk}, 64'd6);
        check(rd_data == '0, "R1 readback clear", 64'(rd_data), 64'd0);
        armed  = 1'b1;
        mon_en = 1'b1;
        step();

        xfer({12'hCBA, 12'h987, 12'h654, 12'h321}, 1'b1);
        xfer('1, 1'b0);
        xfer({12'hAAA, 12'h555, 12'h555, 12'hAAA}, 1'b1);
        xfer('0, 1'b0);
        xfer({12'h800, 12'h001, 12'h001, 12'h800}, 1'b0);
        for (int k = 0; k < 8; k++) begin
            rc = {$urandom, $urandom};
            xfer(rc, k[0]);
            repeat (k) step();
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule